// File: doc/BRIEF.md
# Bayer Color Gain Steering Sequencer

This block chooses, for every pixel that arrives from an image sensor, which one of four programmable 6-bit gain codes applies to it. A 2x2 Bayer color mosaic needs a different gain for each color site. The block follows the two-dimensional position of each pixel using the horizontal (HD) and vertical (VD) sync pulses and a pixel strobe. Within a line, the pixels alternate between the two gains of one pair. The rule that picks the pair depends on the steering mode. In line-alternating mode, meant for progressive sensors, the pair changes from line to line. In field-selected mode, meant for interlaced sensors, the pair changes from field to field.

The four gain codes sit in a small register file that is written through a plain write port (enable, 2-bit address, 6-bit data). For each strobed pixel the block presents the selected gain code and its 2-bit channel index on registered outputs, together with a valid flag, one clock later. The analog gain stage downstream takes the code directly. The sync pulses restart the sequence, so the steering stays locked to the image.

Top module: `bayer_gain_steer`

## Requirements
- R1: Four gain registers of 6 bits each are written with `wr_en`=1, `wr_addr` selecting the register and `wr_data` the code. Channel index n (0..3) always presents register n on `gain_out`.
- R2: A pixel strobe (`pix_en`=1) in clock cycle k makes `out_valid`=1 in cycle k+1, with that pixel's code and channel on `gain_out`/`chan_out`. With no strobe, `out_valid` is 0 in the next cycle and both outputs keep their previous values.
- R3: The channel index is {pair bit, phase bit}. Successive strobed pixels within a line toggle the phase bit (0,1,0,1...), starting from phase 0.
- R4: Only a rising edge of `hd` counts. It resets the phase bit, so the first pixel at or after it uses phase 0. Holding `hd` high does not trigger again.
- R5: In line-alternating mode (`mode`=0) the pair bit is the line parity. Each HD rising edge toggles it, except for the first HD edge after a VD edge, which leaves it at 0.
- R6: A VD rising edge sets the line parity to 0 at once, so the following pixels use channels 0/1, and it resets the phase bit.
- R7: In field-selected mode (`mode`=1) the pair bit is the field parity. It is 0 after reset, toggles on each VD rising edge, and HD edges never change it.
- R8: A sync edge in the same cycle as a pixel strobe takes effect before that pixel is steered.
- R9: A gain write takes effect for strobes in later cycles. A strobe in the same cycle as the write still receives the old code.
- R10: After synchronous reset all gain registers are 0, `gain_out`=0, `chan_out`=0, `out_valid`=0, and the line parity, field parity and phase are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = line-alternating steering, 1 = field-selected steering |
| pix_en | input | 1 | Pixel strobe, one per pixel |
| hd | input | 1 | Horizontal sync level, rising edge starts a line |
| vd | input | 1 | Vertical sync level, rising edge starts a field |
| wr_en | input | 1 | Gain register write enable |
| wr_addr | input | 2 | Gain register index |
| wr_data | input | 6 | Gain code to write |
| gain_out | output | 6 | Gain code of the last strobed pixel |
| chan_out | output | 2 | Channel index {pair, phase} of the last strobed pixel |
| out_valid | output | 1 | High one cycle after a pixel strobe |

## Verification
The assertions assume that every input is synchronous to `clk` and free of unknown values once reset is released. They also assume that sync lines are levels whose rising edges carry meaning. `mode` is assumed to change only while no pixel result is pending, because the pair-bit checks tie a pixel to the mode that was present at its strobe. The stimulus drives all inputs at the falling clock edge and changes `mode` only between fields, after idle cycles. It covers sync edges that coincide with strobes, HD held high across several pixels, and writes that land mid-line on the channel in use.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic {
    STEER_LINE  = 1'b0,
    STEER_FIELD = 1'b1
  } steer_mode_e;

  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CH_W   = $clog2(NUM_CH);

  function automatic logic [CH_W-1:0] make_chan(input logic pair, input logic phase);
    return {pair, phase};
  endfunction
endpackage

// File: rtl/sync_edge.sv
module sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/gain_bank.sv
module gain_bank #(
  parameter int unsigned GAIN_W = 6,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [GAIN_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [GAIN_W-1:0] rdata
);
  logic [GAIN_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/phase_tracker.sv
module phase_tracker
  import bgs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  steer_mode_e       mode,
  input  logic              hd_rise,
  input  logic              vd_rise,
  input  logic              pix_en,
  output logic [CH_W-1:0]   chan
);
  logic phase, line_par, fresh, field;
  logic eff_phase, eff_line, eff_fresh, eff_field, pair;

  always_comb begin
    eff_phase = (hd_rise | vd_rise) ? 1'b0 : phase;
    eff_field = vd_rise ? ~field : field;
    eff_line  = line_par;
    eff_fresh = fresh;
    if (vd_rise) begin
      eff_line  = 1'b0;
      eff_fresh = ~hd_rise;
    end else if (hd_rise) begin
      eff_line  = fresh ? line_par : ~line_par;
      eff_fresh = 1'b0;
    end
    pair = (mode == STEER_FIELD) ? eff_field : eff_line;
    chan = make_chan(pair, eff_phase);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      line_par <= 1'b0;
      fresh    <= 1'b1;
      field    <= 1'b0;
    end else begin
      phase    <= eff_phase ^ pix_en;
      line_par <= eff_line;
      fresh    <= eff_fresh;
      field    <= eff_field;
    end
  end

  assert_alternate_R3: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !hd_rise && !vd_rise) |=> (phase != $past(phase)));

  assert_vd_line_zero_R6: assert property (@(posedge clk) disable iff (rst)
    vd_rise |=> (line_par == 1'b0));

  assert_field_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    vd_rise |=> (field != $past(field)));

  assert_field_hd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !vd_rise |=> $stable(field));
endmodule

// File: rtl/bayer_gain_steer.sv
module bayer_gain_steer #(
  parameter int unsigned GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              pix_en,
  input  logic              hd,
  input  logic              vd,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  output logic [GAIN_W-1:0] gain_out,
  output logic [1:0]        chan_out,
  output logic              out_valid
);
  import bgs_pkg::*;

  localparam int unsigned NSYNC = 2;

  logic [NSYNC-1:0] sync_lvl, sync_rise;
  logic             hd_rise, vd_rise;
  logic [CH_W-1:0]  chan;
  logic [GAIN_W-1:0] sel_gain;
  steer_mode_e      mode_e;

  assign sync_lvl = {vd, hd};
  assign mode_e   = steer_mode_e'(mode);

  for (genvar i = 0; i < NSYNC; i++) begin : g_sync
    sync_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (sync_lvl[i]),
      .rise (sync_rise[i])
    );
  end

  assign hd_rise = sync_rise[0];
  assign vd_rise = sync_rise[1];

  phase_tracker u_track (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_e),
    .hd_rise (hd_rise),
    .vd_rise (vd_rise),
    .pix_en  (pix_en),
    .chan    (chan)
  );

  gain_bank #(.GAIN_W(GAIN_W), .DEPTH(NUM_CH)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (chan),
    .rdata (sel_gain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_out  <= '0;
      chan_out  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pix_en;
      if (pix_en) begin
        gain_out <= sel_gain;
        chan_out <= chan;
      end
    end
  end

  assert_valid_follows_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> out_valid);

  assert_no_valid_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> !out_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(gain_out) && $stable(chan_out)));

  assert_first_even_after_hd_R4: assert property (@(posedge clk) disable iff (rst)
    (hd_rise && pix_en) |=> (chan_out[0] == 1'b0));

  assert_vd_pair_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (vd_rise && pix_en && !mode) |=> (chan_out == 2'd0));
endmodule

// File: tb/sim_bayer_gain_steer.sv
`timescale 1ns/1ps
module sim_bayer_gain_steer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0, pix_en = 1'b0, hd = 1'b0, vd = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic [5:0] gain_out;
  logic [1:0] chan_out;
  logic       out_valid;

  always #4 clk = ~clk;

  bayer_gain_steer u0 (
    .clk(clk), .rst(rst), .mode(mode), .pix_en(pix_en), .hd(hd), .vd(vd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gain_out(gain_out), .chan_out(chan_out), .out_valid(out_valid)
  );

  typedef struct { logic [5:0] g; logic [1:0] c; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  bit m_phase = 0, m_line = 0, m_fresh = 1, m_field = 0, h_prev = 0, v_prev = 0;
  logic [5:0] m_gain [4] = '{default: 6'd0};
  logic [5:0] last_g = '0;
  logic [1:0] last_c = '0;

  task automatic step(input bit pe, input bit h, input bit v, input string tag,
                      input bit we = 0, input logic [1:0] wa = 0, input logic [5:0] wd = 0);
    bit hr, vr;
    logic [1:0] ch;
    pix_en = pe; hd = h; vd = v; wr_en = we; wr_addr = wa; wr_data = wd;
    hr = h & !h_prev; vr = v & !v_prev; h_prev = h; v_prev = v;
    if (vr) begin m_line = 0; m_fresh = 1; m_field = !m_field; m_phase = 0; end
    if (hr) begin
      m_phase = 0;
      if (m_fresh) m_fresh = 0; else m_line = !m_line;
    end
    if (pe) begin
      ch = {(mode ? m_field : m_line), m_phase};
      q.push_back('{m_gain[ch], ch, tag});
      last_g = m_gain[ch]; last_c = ch;
      m_phase = !m_phase;
    end
    if (we) m_gain[wa] = wd;
    @(negedge clk);
  endtask

  task automatic pixels(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops an expected item for each valid output.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) check(0, "R2 unexpected valid", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(gain_out == e.g, {e.tag, " gain"}, gain_out, e.g);
        check(chan_out == e.c, {e.tag, " chan"}, chan_out, e.c);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(0, "watchdog", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(gain_out == 0 && chan_out == 0, "R10 reset outputs", {gain_out, chan_out}, 0);
    check(out_valid == 0, "R10 reset valid", out_valid, 0);
    rst = 1'b0;
    // R10: gains are zero and parities zero right after reset
    pixels(2, "R10");
    step(0, 0, 0, "R1", 1, 2'd0, 6'd5);
    step(0, 0, 0, "R1", 1, 2'd1, 6'd17);
    step(0, 0, 0, "R1", 1, 2'd2, 6'd40);
    step(0, 0, 0, "R1", 1, 2'd3, 6'd63);
    // progressive: VD + HD start line 0
    step(0, 1, 1, "R6");
    pixels(4, "R1 R3 R6");
    step(0, 1, 0, "R5"); pixels(4, "R5 line1");
    step(0, 0, 0, "R5"); step(0, 1, 0, "R5"); pixels(3, "R5 line2");
    // HD held high: no retrigger
    step(0, 0, 0, "R4"); step(0, 1, 0, "R4");
    for (int i = 0; i < 4; i++) step(1, 1, 0, "R4 held");
    // HD edge in same cycle as strobe
    step(0, 0, 0, "R8"); step(1, 1, 0, "R8 hd"); pixels(2, "R8");
    // idle hold check
    step(0, 0, 0, "R2"); step(0, 0, 0, "R2"); step(0, 0, 0, "R2");
    check(out_valid == 0, "R2 idle valid", out_valid, 0);
    check(gain_out == last_g && chan_out == last_c, "R2 hold", gain_out, last_g);
    // mid-line write on channel in use
    step(0, 1, 0, "R9"); step(1, 0, 0, "R9");
    step(1, 0, 0, "R9 same-cycle write", 1, chan_out, 6'd33);
    step(1, 0, 0, "R9"); step(1, 0, 0, "R9"); step(1, 0, 0, "R9 new value");
    // VD mid-line without HD, then first HD keeps line 0
    step(1, 0, 1, "R6 R8 vd"); pixels(2, "R6");
    step(0, 0, 0, "R5"); step(0, 1, 0, "R5 first hd"); pixels(2, "R5");
    step(0, 0, 0, "R5"); step(0, 1, 0, "R5"); pixels(2, "R5 line1");
    // field-selected mode
    step(0, 0, 0, "R7"); step(0, 0, 0, "R7");
    mode = 1'b1;
    for (int f = 0; f < 3; f++) begin
      step(0, 1, 1, "R7 vd");
      for (int l = 0; l < 3; l++) begin
        if (l > 0) begin step(0, 0, 0, "R7"); step(0, 1, 0, "R7 hd"); end
        step(0, 0, 0, "R7");
        for (int p = 0; p < 5; p++) step((p % 3) != 2, 0, 0, "R7 R3");
      end
      step(0, 0, 0, "R7");
    end
    step(1, 0, 1, "R7 R8 vd with pixel"); pixels(3, "R7");
    step(0, 0, 0, "R7"); step(0, 0, 0, "R7");
    mode = 1'b0;
    step(0, 0, 0, "R5");
    for (int l = 0; l < 4; l++) begin
      step(0, 1, 0, "R5"); step(0, 0, 0, "R5");
      for (int p = 0; p < 4; p++) step(1, 0, 0, "R5 R3");
    end
    repeat (3) step(0, 0, 0, "R2");
    check(q.size() == 0, "R2 pending", q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule